// File: doc/BRIEF.md
# Toggle-Coverage Vector Selector

This block picks which test vectors should become quiescent-current measurement points. At the end of every vector the surrounding environment presents a two-bit value for each monitored netlist node and a single contention flag. The block keeps a record of which nodes have already been seen at logic 1 and which at logic 0. It decides whether the vector adds enough new node-values to be worth one of a limited number of measurement slots.

A vector can only be chosen when every node has a known value and no contention is flagged. For such a vector the block counts the node-values it would newly cover. It accepts the vector when that count is at least a programmable percentage of the node-values that are still uncovered. The percentage can be lowered between passes and the accumulated coverage is kept, so more vectors qualify once progress stalls. A synchronous clear starts a fresh selection. A fixed ceiling caps the number of accepted vectors.

Top module: `tvs_top`

## Requirements
- R1: After reset, and in the cycle after `clr_i` is sampled high, `done_o`, `accept_o`, `new_cnt_o`, `cov_cnt_o` and `sel_cnt_o` are all zero. `clr_i` takes priority over `eval_i` sampled at the same edge, and that evaluation is discarded.
- R2: Each `eval_i` sampled high makes `done_o` high for exactly the following cycle. `done_o` is never high without such an evaluation.
- R3: Node codes: 2'b00 is logic 0, 2'b01 is logic 1, and 2'b10 or 2'b11 is unknown. If any node is unknown, the vector is ineligible: `accept_o` is 0, `new_cnt_o` is 0, and coverage and the selection count are unchanged.
- R4: If `contend_i` is high when sampled with `eval_i`, the vector is likewise ineligible, with the same outputs and no state change.
- R5: For an eligible vector, `new_cnt_o` equals the number of nodes at 1 not yet seen at 1 plus the number of nodes at 0 not yet seen at 0.
- R6: An eligible vector is accepted only when `new_cnt_o*100 >= pct_i*U`, where U = 2*NODES - coverage before the vector, and U > 0. `pct_i` is sampled with `eval_i`. A vector evaluated when U is 0 is rejected even with `pct_i` = 0.
- R7: On acceptance, `cov_cnt_o` rises by `new_cnt_o` and the vector's node-values become covered. A rejected vector leaves coverage unchanged, so a later evaluation of the same vector reports the same new count.
- R8: `sel_cnt_o` rises by one per accepted vector. Once it equals MAX_SEL, no further vector is accepted until a clear.
- R9: Lowering `pct_i` keeps all previously accepted coverage. A vector rejected at a high percentage can be accepted at a lower one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of coverage and selection count |
| eval_i | input | 1 | End-of-vector strobe; the other inputs are sampled with it |
| node_val_i | input | 2*NODES | Two-bit code per node; node i occupies bits 2i+1:2i |
| contend_i | input | 1 | Bus contention present in this vector |
| pct_i | input | PCT_W | Acceptance threshold in percent |
| done_o | output | 1 | Evaluation result valid |
| accept_o | output | 1 | Vector accepted as a measurement point |
| new_cnt_o | output | CNT_W | Node-values newly covered by the vector |
| cov_cnt_o | output | CNT_W | Total covered node-values |
| sel_cnt_o | output | SEL_W | Number of accepted vectors |

## Verification
Every result of an evaluation (`done_o`, `accept_o`, `new_cnt_o`, and the updated `cov_cnt_o` and `sel_cnt_o`) is registered once. The results are therefore due in the single cycle after the edge that samples `eval_i`. The bench drives each vector on a falling edge and reads all five outputs on the next falling edge. It checks on the falling edge after that that `done_o` has dropped again. Clear results follow the same one-cycle rule and are read on the falling edge after the clear is sampled.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  // Two-bit node code: bit 1 set means unknown, else bit 0 is the level
  localparam logic [1:0] CODE_LO = 2'b00;
  localparam logic [1:0] CODE_HI = 2'b01;
  localparam int unsigned PCT_SCALE = 100;
endpackage

// File: rtl/tvs_lane.sv
module tvs_lane
  import tvs_pkg::*;
(
  input  logic [1:0] code_i,
  input  logic       seen_hi_i,
  input  logic       seen_lo_i,
  output logic       unk_o,
  output logic       new_hi_o,
  output logic       new_lo_o
);
  always_comb begin
    unk_o    = code_i[1];
    new_hi_o = (code_i == CODE_HI) && !seen_hi_i;
    new_lo_o = (code_i == CODE_LO) && !seen_lo_i;
  end
endmodule

// File: rtl/tvs_popcnt.sv
module tvs_popcnt #(
  parameter int unsigned W     = 32,
  parameter int unsigned OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     bits_i,
  output logic [OUT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + OUT_W'(bits_i[i]);
    end
  end
endmodule

// File: rtl/tvs_judge.sv
module tvs_judge
  import tvs_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned PCT_W = 7,
  localparam int unsigned PROD_W = CNT_W + PCT_W + 1
) (
  input  logic [CNT_W-1:0] new_cnt_i,
  input  logic [CNT_W-1:0] uncov_i,
  input  logic [PCT_W-1:0] pct_i,
  input  logic             elig_i,
  input  logic             room_i,
  output logic             ok_o
);
  logic [PROD_W-1:0] lhs, rhs;
  always_comb begin
    lhs  = PROD_W'(new_cnt_i) * PROD_W'(PCT_SCALE);
    rhs  = PROD_W'(pct_i) * PROD_W'(uncov_i);
    ok_o = elig_i && room_i && (uncov_i != '0) && (lhs >= rhs);
  end
endmodule

// File: rtl/tvs_top.sv
module tvs_top #(
  parameter int unsigned NODES   = 16,
  parameter int unsigned MAX_SEL = 6,
  parameter int unsigned PCT_W   = 7,
  localparam int unsigned VAL_W  = 2 * NODES,
  localparam int unsigned CNT_W  = $clog2(VAL_W + 1),
  localparam int unsigned SEL_W  = $clog2(MAX_SEL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               eval_i,
  input  logic [VAL_W-1:0]   node_val_i,
  input  logic               contend_i,
  input  logic [PCT_W-1:0]   pct_i,
  output logic               done_o,
  output logic               accept_o,
  output logic [CNT_W-1:0]   new_cnt_o,
  output logic [CNT_W-1:0]   cov_cnt_o,
  output logic [SEL_W-1:0]   sel_cnt_o
);
  logic [NODES-1:0] seen_hi_q, seen_lo_q, seen_hi_d, seen_lo_d;
  logic [NODES-1:0] unk_v, new_hi_v, new_lo_v;
  logic [CNT_W-1:0] cov_q, cov_d, newc_q, newc_d, raw_new, uncov;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             done_q, done_d, acc_q, acc_d;
  logic             elig, room, ok;

  for (genvar g = 0; g < NODES; g++) begin : g_lane
    tvs_lane u_lane (
      .code_i   (node_val_i[2*g +: 2]),
      .seen_hi_i(seen_hi_q[g]),
      .seen_lo_i(seen_lo_q[g]),
      .unk_o    (unk_v[g]),
      .new_hi_o (new_hi_v[g]),
      .new_lo_o (new_lo_v[g])
    );
  end

  tvs_popcnt #(.W(VAL_W), .OUT_W(CNT_W)) u_pop (
    .bits_i({new_hi_v, new_lo_v}),
    .cnt_o (raw_new)
  );

  always_comb begin
    elig  = !(|unk_v) && !contend_i;
    room  = (sel_q < SEL_W'(MAX_SEL));
    uncov = CNT_W'(VAL_W) - cov_q;
  end

  tvs_judge #(.CNT_W(CNT_W), .PCT_W(PCT_W)) u_judge (
    .new_cnt_i(raw_new),
    .uncov_i  (uncov),
    .pct_i    (pct_i),
    .elig_i   (elig),
    .room_i   (room),
    .ok_o     (ok)
  );

  // next-state
  always_comb begin
    seen_hi_d = seen_hi_q;
    seen_lo_d = seen_lo_q;
    cov_d     = cov_q;
    sel_d     = sel_q;
    newc_d    = newc_q;
    done_d    = 1'b0;
    acc_d     = 1'b0;
    if (clr_i) begin
      seen_hi_d = '0;
      seen_lo_d = '0;
      cov_d     = '0;
      sel_d     = '0;
      newc_d    = '0;
    end else if (eval_i) begin
      done_d = 1'b1;
      acc_d  = ok;
      newc_d = elig ? raw_new : '0;
      if (ok) begin
        seen_hi_d = seen_hi_q | new_hi_v;
        seen_lo_d = seen_lo_q | new_lo_v;
        cov_d     = cov_q + raw_new;
        sel_d     = sel_q + SEL_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_hi_q <= '0;
      seen_lo_q <= '0;
      cov_q     <= '0;
      sel_q     <= '0;
      newc_q    <= '0;
      done_q    <= 1'b0;
      acc_q     <= 1'b0;
    end else begin
      seen_hi_q <= seen_hi_d;
      seen_lo_q <= seen_lo_d;
      cov_q     <= cov_d;
      sel_q     <= sel_d;
      newc_q    <= newc_d;
      done_q    <= done_d;
      acc_q     <= acc_d;
    end
  end

  assign done_o    = done_q;
  assign accept_o  = acc_q;
  assign new_cnt_o = newc_q;
  assign cov_cnt_o = cov_q;
  assign sel_cnt_o = sel_q;
endmodule

// File: rtl/tvs_chk.sv
module tvs_chk #(
  parameter int unsigned NODES   = 16,
  parameter int unsigned MAX_SEL = 6,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned SEL_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             eval_i,
  input logic             done_o,
  input logic             accept_o,
  input logic [CNT_W-1:0] new_cnt_o,
  input logic [CNT_W-1:0] cov_cnt_o,
  input logic [SEL_W-1:0] sel_cnt_o
);
  // R2
  done_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(eval_i) && !$past(clr_i));
  // R2
  accept_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> done_o);
  // R8
  sel_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cnt_o <= SEL_W'(MAX_SEL));
  // R8
  sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> sel_cnt_o == $past(sel_cnt_o) + SEL_W'(1));
  // R7
  cov_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> cov_cnt_o == $past(cov_cnt_o) + new_cnt_o);
  // R7
  cov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_o && !$past(clr_i)) |-> $stable(cov_cnt_o));
  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (cov_cnt_o == '0 && sel_cnt_o == '0 && !done_o));
  // R7
  cov_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cov_cnt_o <= CNT_W'(2 * NODES));
endmodule

bind tvs_top tvs_chk #(
  .NODES(NODES), .MAX_SEL(MAX_SEL), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .eval_i(eval_i),
  .done_o(done_o), .accept_o(accept_o), .new_cnt_o(new_cnt_o),
  .cov_cnt_o(cov_cnt_o), .sel_cnt_o(sel_cnt_o)
);

// File: tb/tb_tvs_top.sv
module tb_tvs_top;
  localparam int N     = 16;
  localparam int MAXS  = 6;
  localparam int PW    = 7;
  localparam int VW    = 2 * N;
  localparam int CW    = $clog2(VW + 1);
  localparam int SW    = $clog2(MAXS + 1);

  logic clk = 1'b0;
  logic rst_n, clr, ev, ct;
  logic [VW-1:0] vals;
  logic [PW-1:0] pct;
  logic done, acc;
  logic [CW-1:0] newc, cov;
  logic [SW-1:0] sel;

  int errs = 0, checks = 0;
  logic [N-1:0] m_hi, m_lo;
  int m_sel, m_cov;

  always #2 clk = ~clk;

  tvs_top #(.NODES(N), .MAX_SEL(MAXS), .PCT_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .eval_i(ev), .node_val_i(vals),
    .contend_i(ct), .pct_i(pct), .done_o(done), .accept_o(acc),
    .new_cnt_o(newc), .cov_cnt_o(cov), .sel_cnt_o(sel)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_new(input logic [VW-1:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) begin
      if (v[2*i+1]) n = n;
      else if (v[2*i] && !m_hi[i]) n++;
      else if (!v[2*i] && !m_lo[i]) n++;
    end
    return n;
  endfunction

  function automatic bit has_unk(input logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (v[2*i+1]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_clear();
    m_hi = '0; m_lo = '0; m_sel = 0; m_cov = 0;
  endtask

  task automatic run_vec(input logic [VW-1:0] v, input bit c, input int p, input string req);
    bit elig, ok;
    int nw, unc;
    elig = !has_unk(v) && !c;
    nw   = elig ? exp_new(v) : 0;
    unc  = VW - m_cov;
    ok   = elig && (m_sel < MAXS) && (unc > 0) && (nw * 100 >= p * unc);
    @(negedge clk);
    cmp("R2", "done idle", int'(done), 0);
    vals = v; ct = c; pct = PW'(p); ev = 1'b1;
    @(negedge clk);
    ev = 1'b0;
    if (ok) begin
      for (int i = 0; i < N; i++) begin
        if (!v[2*i+1] && v[2*i])  m_hi[i] = 1'b1;
        if (!v[2*i+1] && !v[2*i]) m_lo[i] = 1'b1;
      end
      m_cov += nw;
      m_sel++;
    end
    cmp("R2", {req, " done"}, int'(done), 1);
    cmp(req, "accept", int'(acc), int'(ok));
    cmp("R5", {req, " new_cnt"}, int'(newc), nw);
    cmp("R7", {req, " cov_cnt"}, int'(cov), m_cov);
    cmp("R8", {req, " sel_cnt"}, int'(sel), m_sel);
  endtask

  task automatic do_clear(input bit with_eval);
    @(negedge clk);
    clr = 1'b1; ev = with_eval; vals = '0; ct = 1'b0; pct = PW'(10);
    @(negedge clk);
    clr = 1'b0; ev = 1'b0;
    model_clear();
    cmp("R1", "clr done", int'(done), 0);
    cmp("R1", "clr accept", int'(acc), 0);
    cmp("R1", "clr new", int'(newc), 0);
    cmp("R1", "clr cov", int'(cov), 0);
    cmp("R1", "clr sel", int'(sel), 0);
  endtask

  function automatic logic [VW-1:0] rand_vec(input bit allow_unk);
    logic [VW-1:0] v;
    for (int i = 0; i < N; i++) begin
      v[2*i]   = 1'($urandom);
      v[2*i+1] = allow_unk && ($urandom % 20 == 0);
    end
    return v;
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0] all0, all1, half;
    int plist[5];
    void'($urandom(32'd1234));
    plist = '{50, 20, 10, 5, 0};
    all0 = '0;
    all1 = '0;
    for (int i = 0; i < N; i++) all1[2*i] = 1'b1;
    half = '0;
    for (int i = 0; i < N / 2; i++) half[2*i] = 1'b1;
    rst_n = 1'b0; clr = 1'b0; ev = 1'b0; ct = 1'b0; vals = '0; pct = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", "reset done", int'(done), 0);
    cmp("R1", "reset accept", int'(acc), 0);
    cmp("R1", "reset cov", int'(cov), 0);
    cmp("R1", "reset sel", int'(sel), 0);
    cmp("R1", "reset new", int'(newc), 0);

    // R3: unknown node blocks selection
    begin
      logic [VW-1:0] u;
      u = all0; u[5] = 1'b1;
      run_vec(u, 1'b0, 10, "R3");
    end
    // R4: contention blocks selection
    run_vec(all0, 1'b1, 10, "R4");
    // R6: first eligible vector, N new out of 2N
    run_vec(all0, 1'b0, 10, "R6");
    // R7: same vector again, nothing new, rejected
    run_vec(all0, 1'b0, 10, "R7");
    // R9: half-new vector rejected at 60, then accepted at 50
    run_vec(half, 1'b0, 60, "R9");
    run_vec(half, 1'b0, 50, "R9");
    // R6: pct 0 accepts even zero-gain vector while uncovered remain
    run_vec(half, 1'b0, 0, "R6");
    run_vec(all1, 1'b0, 100, "R6");
    // R6: full coverage, rejected even at pct 0
    run_vec(all1, 1'b0, 0, "R6");
    // R8: fill remaining selections then check ceiling
    do_clear(1'b0);
    for (int k = 0; k < MAXS + 2; k++) run_vec(rand_vec(1'b0), 1'b0, 0, "R8");
    // R1: clear wins over simultaneous evaluation
    do_clear(1'b1);

    for (int k = 0; k < 400; k++) begin
      if (k % 40 == 39) do_clear(1'b0);
      run_vec(rand_vec(1'b1), ($urandom % 10 == 0), plist[(k / 8) % 5], "R6");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule